// File: doc/BRIEF.md
# Sync Presence Hysteresis Detector

This block judges whether an external horizontal sync signal is present. Once per line period a strobe arrives together with a flag that says whether sync was seen during that line. The block counts runs of consecutive lines. A run of lines with sync moves the judgement from absent to present. A run of lines without sync moves it back from present to absent.

The two run lengths are set separately, each by a one-hot code, so the two transitions have different thresholds. A short acquire threshold and a long loss threshold give hysteresis, so that a noisy source does not make the flag toggle. One setting of the loss code turns loss detection off, and the flag then stays high once it is set. The registered flag can drive a status pin or cause a switch to internally generated timing.

Top module: `sync_presence_detector`

## Requirements
- R1: During reset and directly after it, `sync_present` is low.
- R2: The acquire code `acq_code` selects how many consecutive strobed lines with `sync_seen` high are needed to raise the flag: 3'b000 needs 1 line, 3'b001 needs 4, 3'b010 needs 8 and 3'b100 needs 16. The flag rises at the clock edge that samples the last line of the run.
- R3: The loss code `loss_code` selects how many consecutive strobed lines with `sync_seen` low are needed to drop the flag: 4'b0001 needs 32, 4'b0010 needs 64, 4'b0100 needs 128 and 4'b1000 needs 256.
- R4: While `loss_code` is 4'b0000, the flag never falls, however many lines without sync arrive.
- R5: A line that breaks the current run clears the run count. While absent, this is a line without sync. While present, it is a line with sync. The full threshold must then be met again from zero.
- R6: A code with more than one bit set behaves as the code that keeps only its highest set bit.
- R7: The flag changes only at a clock edge where `line_stb` is high. Changes of `sync_seen` or of either code without a strobe leave the flag unchanged.
- R8: A strobed line with sync never lowers the flag, and a strobed line without sync never raises it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb | input | 1 | One-cycle pulse, once per line period |
| sync_seen | input | 1 | Sync was detected during the line being strobed |
| acq_code | input | 3 | One-hot acquire threshold code |
| loss_code | input | 4 | One-hot loss threshold code, zero disables loss |
| sync_present | output | 1 | Registered judgement that sync is present |

## Verification
The only internal state is the run count and the flag. A wrong run count shows at the port only when a run ends. It appears as a flag edge that comes early or late against the selected threshold, so it can take up to 256 lines to see. For that reason, the sweep checks the flag one line before the threshold and on the threshold line, for every acquire and loss code including the multi-hot ones. Broken runs are also tested, to show that a leftover count moves the edge. A wrong flag register shows at once, as an edge without a strobe or with the wrong sync value.

// File: rtl/spd_pkg.sv
package spd_pkg;

  // Position of the highest set bit plus one; zero when no bit is set.
  function automatic int unsigned top_bit_rank(input logic [15:0] code);
    int unsigned rank;
    rank = 0;
    for (int k = 0; k < 16; k++) begin
      if (code[k]) rank = k + 1;
    end
    return rank;
  endfunction

  // Run length selected by a one-hot code whose bit k stands for unit << k.
  function automatic int unsigned code_to_lines(input logic [15:0] code,
                                                input int unsigned unit);
    int unsigned rank;
    rank = top_bit_rank(code);
    return (rank == 0) ? 0 : (unit << (rank - 1));
  endfunction

endpackage

// File: rtl/spd_thresh_decode.sv
module spd_thresh_decode #(
  parameter int CODE_W = 3,
  parameter int UNIT   = 4,
  parameter int OUT_W  = 9
) (
  input  logic [CODE_W-1:0] code,
  output logic [OUT_W-1:0]  lines
);
  import spd_pkg::*;

  always_comb begin
    lines = OUT_W'(code_to_lines(16'(code), UNIT));
  end
endmodule

// File: rtl/spd_run_counter.sv
module spd_run_counter #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic [W-1:0] count_next_inc
);
  // Saturating successor; the counter never wraps to zero.
  assign count_next_inc = (&count) ? count : count + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count_next_inc;
  end
endmodule

// File: rtl/spd_judge.sv
module spd_judge #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         line_stb,
  input  logic         sync_seen,
  input  logic [W-1:0] run_succ,
  input  logic [W-1:0] acq_lines,
  input  logic [W-1:0] loss_lines,
  output logic         run_clr,
  output logic         run_inc,
  output logic         acquire_hit,
  output logic         loss_hit,
  output logic         present
);
  logic loss_off;
  logic run_break;

  assign loss_off    = (loss_lines == '0);
  assign acquire_hit = !present && line_stb && sync_seen && (run_succ >= acq_lines);
  assign loss_hit    = present && line_stb && !sync_seen && !loss_off
                       && (run_succ >= loss_lines);
  assign run_break   = line_stb && (present ? sync_seen : !sync_seen);
  assign run_clr     = acquire_hit || loss_hit || run_break
                       || (present && line_stb && loss_off);
  assign run_inc     = line_stb && !run_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           present <= 1'b0;
    else if (acquire_hit) present <= 1'b1;
    else if (loss_hit)    present <= 1'b0;
  end
endmodule

// File: rtl/sync_presence_detector.sv
module sync_presence_detector #(
  parameter int ACQ_W     = 3,
  parameter int LOSS_W    = 4,
  parameter int ACQ_UNIT  = 4,
  parameter int LOSS_UNIT = 32,
  localparam int RUN_W    = $clog2(LOSS_UNIT << (LOSS_W - 1)) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_stb,
  input  logic              sync_seen,
  input  logic [ACQ_W-1:0]  acq_code,
  input  logic [LOSS_W-1:0] loss_code,
  output logic              sync_present
);
  logic [RUN_W-1:0] acq_lines;
  logic [RUN_W-1:0] loss_lines;
  logic [RUN_W-1:0] run_count;
  logic [RUN_W-1:0] run_succ;
  logic             run_clr;
  logic             run_inc;
  logic             acquire_hit;
  logic             loss_hit;

  spd_thresh_decode #(.CODE_W(ACQ_W), .UNIT(ACQ_UNIT), .OUT_W(RUN_W)) u_acq_dec (
    .code (acq_code),
    .lines(acq_lines)
  );

  spd_thresh_decode #(.CODE_W(LOSS_W), .UNIT(LOSS_UNIT), .OUT_W(RUN_W)) u_loss_dec (
    .code (loss_code),
    .lines(loss_lines)
  );

  spd_run_counter #(.W(RUN_W)) u_run (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr           (run_clr),
    .inc           (run_inc),
    .count         (run_count),
    .count_next_inc(run_succ)
  );

  spd_judge #(.W(RUN_W)) u_judge (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_stb   (line_stb),
    .sync_seen  (sync_seen),
    .run_succ   (run_succ),
    .acq_lines  (acq_lines),
    .loss_lines (loss_lines),
    .run_clr    (run_clr),
    .run_inc    (run_inc),
    .acquire_hit(acquire_hit),
    .loss_hit   (loss_hit),
    .present    (sync_present)
  );
endmodule

// File: rtl/spd_checker.sv
module spd_checker #(
  parameter int RUN_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_stb,
  input logic             sync_seen,
  input logic [2:0]       acq_code,
  input logic [3:0]       loss_code,
  input logic             sync_present,
  input logic [RUN_W-1:0] run_count
);
  a_r1_low_in_reset: assert property (@(posedge clk) !rst_n |=> !sync_present);

  a_r7_no_strobe_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> $stable(sync_present));

  a_r8_rise_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_present) |-> $past(line_stb && sync_seen));

  a_r8_fall_needs_miss: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_present) |-> $past(line_stb && !sync_seen));

  a_r4_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_present && loss_code == 4'b0000) |=> sync_present);

  a_r2_instant_acquire: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_present && line_stb && sync_seen && acq_code == 3'b000) |=> sync_present);

  a_r5_break_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && (sync_present ? sync_seen : !sync_seen)) |=> (run_count == '0));
endmodule

bind sync_presence_detector spd_checker #(.RUN_W(RUN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_stb    (line_stb),
  .sync_seen   (sync_seen),
  .acq_code    (acq_code),
  .loss_code   (loss_code),
  .sync_present(sync_present),
  .run_count   (run_count)
);

// File: tb/sync_presence_detector_tb.sv
module sync_presence_detector_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_stb = 1'b0;
  logic       sync_seen = 1'b0;
  logic [2:0] acq_code = 3'b000;
  logic [3:0] loss_code = 4'b0000;
  logic       sync_present;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sync_presence_detector u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_stb    (line_stb),
    .sync_seen   (sync_seen),
    .acq_code    (acq_code),
    .loss_code   (loss_code),
    .sync_present(sync_present)
  );

  // Thresholds from the requirement tables: highest set bit k gives unit * 2^k.
  function automatic int acq_need(input logic [2:0] c);
    if (c[2]) return 16;
    if (c[1]) return 8;
    if (c[0]) return 4;
    return 1;
  endfunction

  function automatic int loss_need(input logic [3:0] c);
    int n;
    n = 0;
    for (int k = 0; k < 4; k++) if (c[k]) n = 32 * (2 ** k);
    return n;
  endfunction

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: sync_present=%0b expected %0b", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    line_stb = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic line(input logic s);
    @(negedge clk);
    line_stb = 1'b1;
    sync_seen = s;
    @(negedge clk);
    line_stb = 1'b0;
  endtask

  task automatic lines(input logic s, input int n);
    for (int i = 0; i < n; i++) line(s);
  endtask

  initial begin
    // R1 reset state
    do_reset();
    check(sync_present, 1'b0, "R1");

    // R2 / R6 acquire sweep over every 3-bit code
    for (int c = 0; c < 8; c++) begin
      acq_code = 3'(c);
      loss_code = 4'b0000;
      do_reset();
      if (acq_need(3'(c)) > 1) begin
        lines(1'b1, acq_need(3'(c)) - 1);
        check(sync_present, 1'b0, (c == 3 || c > 4) ? "R6 before acquire" : "R2 before acquire");
      end
      line(1'b1);
      check(sync_present, 1'b1, (c == 3 || c > 4) ? "R6 at acquire" : "R2 at acquire");
    end

    // R3 / R4 / R6 loss sweep over every 4-bit code
    for (int c = 0; c < 16; c++) begin
      acq_code = 3'b000;
      loss_code = 4'(c);
      do_reset();
      line(1'b1);
      if (c == 0) begin
        lines(1'b0, 300);
        check(sync_present, 1'b1, "R4 loss disabled");
      end else begin
        lines(1'b0, loss_need(4'(c)) - 1);
        check(sync_present, 1'b1, ($countones(c) > 1) ? "R6 before loss" : "R3 before loss");
        line(1'b0);
        check(sync_present, 1'b0, ($countones(c) > 1) ? "R6 at loss" : "R3 at loss");
      end
    end

    // R5 broken acquire run restarts from zero
    acq_code = 3'b010;
    loss_code = 4'b0001;
    do_reset();
    lines(1'b1, 7);
    line(1'b0);
    lines(1'b1, 7);
    check(sync_present, 1'b0, "R5 acquire restart");
    line(1'b1);
    check(sync_present, 1'b1, "R5 acquire after restart");

    // R5 broken loss run restarts from zero; R8 sync lines keep flag high
    lines(1'b0, 31);
    line(1'b1);
    check(sync_present, 1'b1, "R8 sync line keeps flag");
    lines(1'b0, 31);
    check(sync_present, 1'b1, "R5 loss restart");
    line(1'b0);
    check(sync_present, 1'b0, "R5 loss after restart");

    // R8 missing lines keep the flag low
    lines(1'b0, 40);
    check(sync_present, 1'b0, "R8 miss line keeps low");

    // R7 no strobe: toggling inputs changes nothing
    acq_code = 3'b000;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      sync_seen = ~sync_seen;
    end
    check(sync_present, 1'b0, "R7 no strobe while absent");
    line(1'b1);
    loss_code = 4'b0001;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      sync_seen = 1'b0;
      loss_code = 4'(i);
    end
    check(sync_present, 1'b1, "R7 no strobe while present");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule